// File: doc/BRIEF.md
# Low-Power Sleep Sequencer for a Synchronous SRAM

This block controls the power-saving sleep state of a synchronous static memory. A sleep request pin arrives with no fixed relation to the clock. The block passes it through a flop synchroniser, then steps through a fixed sequence of phases to enter sleep and to leave it. While the sequence is not in its normal running phase, the block blocks the start of any access. Stored data is meant to survive sleep, but the storage array itself sits outside this block.

An access that is still outstanding when the sequence begins to enter sleep is reported as aborted. This lets the surrounding logic discard it. After the request pin falls, the block runs an exit phase and then a recovery window. During both, the chip enables and the address strobes must stay idle. Any activity during these quiet phases, or while entry is in progress, raises a sticky violation flag, and the access is refused.

Top module: `sleep_seq`

## Requirements
- R1: After reset, `access_ok` is 1 and `sleeping`, `viol`, `pend_abort` and `start_ok` are 0.
- R2: `sleep_pin` passes through two synchroniser flops before the sequencer sees it. After a rising pin, `access_ok` is still 1 following the second clock edge and drops to 0 on the third edge.
- R3: Entry takes exactly two cycles. `sleeping` rises on the fifth edge after the pin rises, and `access_ok` stays 0 from the third edge onward.
- R4: `sleeping` stays 1 for as long as the synchronised pin is high. After the pin falls, `sleeping` drops on the third edge. An exit phase of two cycles follows, then a recovery window of two cycles, and `access_ok` returns on the seventh edge.
- R5: `start_ok` is 1 only when `access_ok` is 1, every bit of `ce_act` is 1, and at least one bit of `strb_act` is 1. Outside the awake phase it is 0, even with a full request.
- R6: While asleep, enables and strobes start no access and do not set `viol`.
- R7: Any set bit of `ce_act` or `strb_act` during the entering, exiting or recovery phase sets `viol` at the next edge. `viol` then stays 1 until reset.
- R8: `pend_abort` is 1 for exactly the one cycle after the edge that moves the sequencer from awake into entry, if `pend_in` was 1 at that edge. It stays 0 when `pend_in` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_pin | input | 1 | Asynchronous sleep request, high requests sleep |
| ce_act | input | NUM_CE | Chip enables, 1 = enable active |
| strb_act | input | NUM_STRB | Address strobes, 1 = strobe active |
| pend_in | input | 1 | An access is outstanding |
| sleeping | output | 1 | Sequencer is in the sleep phase |
| access_ok | output | 1 | Sequencer is awake and may start accesses |
| start_ok | output | 1 | A requested access start is let through |
| viol | output | 1 | Sticky flag for activity during a quiet phase |
| pend_abort | output | 1 | One-cycle pulse: outstanding access discarded at sleep entry |

## Verification
A phase counter that loads the wrong value, or a state that skips a phase, changes the edge on which `sleeping` or `access_ok` toggles. The bench samples these outputs on every single edge of a full sleep round trip, so such a fault shows up within one cycle of the wrong transition. A quiet-phase decode that is wrong shows at `viol` one edge after the offending stimulus, or as a missing assertion of `viol` there. A fault in the abort capture shows as a wrong `pend_abort` pulse on the entry edge.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE    = 3'd0,
    ST_ENTERING = 3'd1,
    ST_ASLEEP   = 3'd2,
    ST_EXITING  = 3'd3,
    ST_RECOVERY = 3'd4
  } slp_st_e;

  // largest of three phase lengths, used to size the phase counter
  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // cycles spent in a timed phase; untimed phases return 1
  function automatic int phase_len(input slp_st_e st, input int ent,
                                   input int ext, input int rec);
    case (st)
      ST_ENTERING: return ent;
      ST_EXITING:  return ext;
      ST_RECOVERY: return rec;
      default:     return 1;
    endcase
  endfunction

  // phases in which enables and strobes must stay idle
  function automatic logic quiet_phase(input slp_st_e st);
    return (st == ST_ENTERING) || (st == ST_EXITING) || (st == ST_RECOVERY);
  endfunction

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2,
  parameter int REC_CYC   = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_s,
  output slp_st_e state,
  output logic    phase_last
);
  localparam int MAX_LEN = max3(ENTRY_CYC, EXIT_CYC, REC_CYC);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  slp_st_e          nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign phase_last = (int'(cnt) == phase_len(state, ENTRY_CYC, EXIT_CYC, REC_CYC) - 1);

  always_comb begin
    nxt     = state;
    cnt_nxt = '0;
    case (state)
      ST_AWAKE:    if (req_s) nxt = ST_ENTERING;
      ST_ENTERING: if (phase_last) nxt = ST_ASLEEP;   else cnt_nxt = cnt + 1'b1;
      ST_ASLEEP:   if (!req_s) nxt = ST_EXITING;
      ST_EXITING:  if (phase_last) nxt = ST_RECOVERY; else cnt_nxt = cnt + 1'b1;
      ST_RECOVERY: if (phase_last) nxt = ST_AWAKE;    else cnt_nxt = cnt + 1'b1;
      default:     nxt = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_AWAKE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end

  AST_ENTRY_TO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTERING) |=> (state == ST_ENTERING || state == ST_ASLEEP)); // R3
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ASLEEP && req_s) |=> (state == ST_ASLEEP)); // R4
  AST_WAKE_VIA_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AWAKE && $past(state) != ST_AWAKE) |-> ($past(state) == ST_RECOVERY)); // R4
endmodule

// File: rtl/sleep_guard.sv
module sleep_guard
  import sleep_pkg::*;
#(
  parameter int NUM_CE   = 3,
  parameter int NUM_STRB = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  slp_st_e             state,
  input  logic                req_s,
  input  logic [NUM_CE-1:0]   ce_act,
  input  logic [NUM_STRB-1:0] strb_act,
  input  logic                pend_in,
  output logic                access_ok,
  output logic                start_ok,
  output logic                viol,
  output logic                pend_abort
);
  logic activity, quiet_hit, entry_edge;

  assign access_ok  = (state == ST_AWAKE);
  assign activity   = (|ce_act) | (|strb_act);
  assign quiet_hit  = quiet_phase(state) & activity;
  assign entry_edge = (state == ST_AWAKE) & req_s;
  assign start_ok   = access_ok & (&ce_act) & (|strb_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol       <= 1'b0;
      pend_abort <= 1'b0;
    end else begin
      viol       <= viol | quiet_hit;
      pend_abort <= entry_edge & pend_in;
    end
  end

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R7
  AST_START_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (state == ST_AWAKE)); // R5
  AST_ABORT_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pend_abort |-> (state == ST_ENTERING)); // R8
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_pkg::*;
#(
  parameter int NUM_CE      = 3,
  parameter int NUM_STRB    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int REC_CYC     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_pin,
  input  logic [NUM_CE-1:0]   ce_act,
  input  logic [NUM_STRB-1:0] strb_act,
  input  logic                pend_in,
  output logic                sleeping,
  output logic                access_ok,
  output logic                start_ok,
  output logic                viol,
  output logic                pend_abort
);
  logic    req_s;
  logic    phase_last;
  slp_st_e state;

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sleep_pin), .q_sync(req_s)
  );

  sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC), .REC_CYC(REC_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .state(state), .phase_last(phase_last)
  );

  sleep_guard #(.NUM_CE(NUM_CE), .NUM_STRB(NUM_STRB)) u_guard (
    .clk(clk), .rst_n(rst_n), .state(state), .req_s(req_s),
    .ce_act(ce_act), .strb_act(strb_act), .pend_in(pend_in),
    .access_ok(access_ok), .start_ok(start_ok), .viol(viol), .pend_abort(pend_abort)
  );

  assign sleeping = (state == ST_ASLEEP);

  AST_NO_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> !start_ok); // R6
endmodule

// File: tb/sim_sleep_seq.sv
module sim_sleep_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CE = 3;
  localparam int NUM_STRB = 2;
  localparam int NVEC = 15;

  // {pin, ce_all, strb[1:0], pend, exp_ok, exp_sleep, exp_viol, exp_abort, exp_start}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0_00_1_1_0_0_0_0,  // edge1: first sync flop only       R2
    10'b1_0_00_1_1_0_0_0_0,  // edge2: still awake                R2
    10'b1_0_00_1_0_0_0_1_0,  // edge3: entering, abort pulse      R2 R8
    10'b1_0_00_0_0_0_0_0_0,  // edge4: second entry cycle         R3
    10'b1_0_00_0_0_1_0_0_0,  // edge5: asleep                     R3
    10'b0_1_11_0_0_1_0_0_0,  // edge6: asleep, access ignored     R6
    10'b0_0_00_0_0_1_0_0_0,  // edge7: still asleep               R4
    10'b0_0_00_0_0_0_0_0_0,  // edge8: exiting                    R4
    10'b0_0_00_0_0_0_0_0_0,
    10'b0_0_00_0_0_0_0_0_0,  // recovery
    10'b0_0_00_0_0_0_0_0_0,
    10'b0_0_00_0_1_0_0_0_0,  // edge12: awake again               R4
    10'b0_1_01_0_1_0_0_0_1,  // full request starts               R5
    10'b0_1_10_0_1_0_0_0_1,  // other strobe starts               R5
    10'b0_0_11_0_1_0_0_0_0   // strobes without enables           R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_pin = 1'b0;
  logic [NUM_CE-1:0] ce_act = '0;
  logic [NUM_STRB-1:0] strb_act = '0;
  logic pend_in = 1'b0;
  logic sleeping, access_ok, start_ok, viol, pend_abort;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_seq #(.NUM_CE(NUM_CE), .NUM_STRB(NUM_STRB)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_pin(sleep_pin), .ce_act(ce_act),
    .strb_act(strb_act), .pend_in(pend_in), .sleeping(sleeping),
    .access_ok(access_ok), .start_ok(start_ok), .viol(viol), .pend_abort(pend_abort)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    ce_act = '0;
    strb_act = '0;
    pend_in = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    #1;
    chk("R1 access_ok", access_ok, 1'b1);
    chk("R1 sleeping", sleeping, 1'b0);
    chk("R1 viol", viol, 1'b0);
    chk("R1 pend_abort", pend_abort, 1'b0);
    chk("R1 start_ok", start_ok, 1'b0);

    // table walk: one full round trip plus start gating
    for (int v = 0; v < NVEC; v++) begin
      sleep_pin = VEC[v][9];
      ce_act    = {NUM_CE{VEC[v][8]}};
      strb_act  = VEC[v][7:6];
      pend_in   = VEC[v][5];
      step(1);
      chk($sformatf("R2/R3/R4 vec%0d access_ok", v), access_ok, VEC[v][4]);
      chk($sformatf("R3/R4/R6 vec%0d sleeping", v), sleeping, VEC[v][3]);
      chk($sformatf("R6/R7 vec%0d viol", v), viol, VEC[v][2]);
      chk($sformatf("R8 vec%0d pend_abort", v), pend_abort, VEC[v][1]);
      chk($sformatf("R5 vec%0d start_ok", v), start_ok, VEC[v][0]);
    end
    idle_inputs();

    // R8 negative: entry with nothing outstanding, R7: enable during entry
    sleep_pin = 1'b1;
    step(3);
    chk("R8 no abort without pending", pend_abort, 1'b0);
    chk("R3 entering blocks access", access_ok, 1'b0);
    ce_act = 3'b001;
    chk("R5 no start while entering", start_ok, 1'b0);
    step(1);
    chk("R7 enable during entry sets viol", viol, 1'b1);
    ce_act = '0;
    step(8);
    chk("R4 long sleep held", sleeping, 1'b1);
    sleep_pin = 1'b0;
    step(7);
    chk("R7 viol sticky after wake", viol, 1'b1);
    chk("R4 awake after round trip", access_ok, 1'b1);

    // reset clears the sticky flag
    rst_n = 1'b0;
    step(1);
    rst_n = 1'b1;
    #1;
    chk("R1 viol cleared by reset", viol, 1'b0);
    chk("R1 access_ok after reset", access_ok, 1'b1);

    // R7: strobe only during recovery
    sleep_pin = 1'b1;
    step(5);
    chk("R3 asleep again", sleeping, 1'b1);
    sleep_pin = 1'b0;
    step(5);
    chk("R4 in recovery, access blocked", access_ok, 1'b0);
    chk("R7 quiet so far", viol, 1'b0);
    strb_act = 2'b01;
    ce_act = 3'b111;
    #1;
    chk("R5 start refused in recovery", start_ok, 1'b0);
    step(1);
    chk("R7 strobe in recovery sets viol", viol, 1'b1);
    idle_inputs();
    step(1);
    chk("R4 awake after recovery", access_ok, 1'b1);
    chk("R7 viol still held", viol, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule